// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block gathers three timekeeping events (alarm match, periodic tick and update-complete) and turns them into one active-low interrupt request. Each event arrives as a single-cycle pulse and sets its own sticky flag. A flag sets whether or not its enable is on. The request line is driven while any flag meets its enable. Software reads a status byte that holds the three flags and a summary bit. Reading that byte clears it.

A status read is protected against races. The status value is captured when the read strobe begins and is returned unchanged for as long as the strobe is held. All captured flags clear when the strobe ends. An event that fires while the strobe is active is parked and written into its flag only after the clear, so no event is lost.

Register access uses a chip select, read and write strobes, a one-bit address and an 8-bit data path. Address 0 is the enable register, which can be read and written. Address 1 is the status register, which is read-only.

Top module: `evt_irq_hub`

## Requirements
- R1: While `rst_ni` is low, `irq_no` is high. After reset all flags, enables and parked events are zero, so a status read returns 0x00 and an enable read returns 0x00.
- R2: A pulse on an event input while no status read strobe is active sets that source's flag on the next clock edge, for any enable value.
- R3: Field layout in both registers: bit 6 is periodic, bit 5 is alarm and bit 4 is update-complete. Bits 3 to 0 always read 0. Writing address 0 loads bits 6..4 as enables, and reading address 0 returns them at the same positions with the other bits 0.
- R4: `irq_no` is low exactly when some source has both its flag and its enable set. If a flag is already set, writing its enable drives `irq_no` low from the cycle after the write edge.
- R5: Bit 7 of a status read is 1 exactly when `irq_no` was low in the cycle the read strobe began.
- R6: A status read is `cs_i & rd_i & addr_i` held high. From the cycle after the strobe rises until the strobe falls, `rdata_o` shows the status captured at the rising cycle and does not change.
- R7: When the status read strobe falls, every flag and the summary bit clear. With no event during the read, `irq_no` is high and the next status read returns 0x00.
- R8: An event pulse that arrives while a status read strobe is active, including in its first cycle, is left out of that read's value and is set into its flag when the strobe falls.
- R9: Any combination of the three flags, from one to all three, can be returned together in one status value.
- R10: A write to address 1 changes neither the flags nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_i | input | 1 | Register chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 1 | Register select: 0 = enable register, 1 = status register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| ev_alarm_i | input | 1 | Alarm event pulse |
| ev_periodic_i | input | 1 | Periodic event pulse |
| ev_update_i | input | 1 | Update-complete event pulse |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The checker assumes that event inputs and register strobes are synchronous to `clk_i`. It also assumes that a status read strobe is held for at least two cycles, so a captured value exists to be held stable, and that strobes appear only outside reset. The stimulus changes every input on the falling clock edge. It issues one register access at a time and keeps status strobes between two and five cycles long. Event pulses last exactly one cycle and are placed either before a read or at a chosen cycle inside one, including the cycle in which the read starts.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DW      = 8;
  localparam int NSRC    = 3;
  localparam int SRC_LSB = 4;
  localparam int BIT_SUM = 7;

  // Source index inside the event vector; status bit is SRC_LSB + index
  localparam int IDX_UPD = 0;
  localparam int IDX_ALM = 1;
  localparam int IDX_PER = 2;

  typedef logic [NSRC-1:0] srcvec_t;
  typedef logic [DW-1:0]   byte_t;

  typedef enum logic [0:0] {
    RD_IDLE = 1'b0,
    RD_HOLD = 1'b1
  } rd_state_e;

  function automatic byte_t pack_status(input logic sum, input srcvec_t f);
    byte_t r;
    r = '0;
    r[BIT_SUM] = sum;
    r[SRC_LSB +: NSRC] = f;
    return r;
  endfunction

  function automatic byte_t pack_enable(input srcvec_t e);
    byte_t r;
    r = '0;
    r[SRC_LSB +: NSRC] = e;
    return r;
  endfunction
endpackage

// File: rtl/evt_irq_rstsync.sv
module evt_irq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign srst_no = sync_q[STAGES-1];
endmodule

// File: rtl/evt_irq_capture.sv
module evt_irq_capture
  import evt_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  srcvec_t evt_i,
  input  logic    freeze_i,
  input  logic    done_i,
  output srcvec_t flags_o,
  output srcvec_t pend_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic flag_q, flag_d, flag_en;
    logic pend_q, pend_d, pend_en;

    always_comb begin
      flag_d  = flag_q;
      flag_en = 1'b0;
      pend_d  = pend_q;
      pend_en = 1'b0;
      if (done_i) begin
        flag_d  = pend_q | evt_i[k];
        flag_en = 1'b1;
        pend_d  = 1'b0;
        pend_en = 1'b1;
      end else if (freeze_i) begin
        pend_d  = pend_q | evt_i[k];
        pend_en = evt_i[k];
      end else begin
        flag_d  = 1'b1;
        flag_en = evt_i[k];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_q <= 1'b0;
      else if (pend_en) pend_q <= pend_d;
    end

    assign flags_o[k] = flag_q;
    assign pend_o[k]  = pend_q;
  end
endmodule

// File: rtl/evt_irq_rdport.sv
module evt_irq_rdport
  import evt_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    access_i,
  input  srcvec_t flags_i,
  input  logic    irq_act_i,
  output logic    freeze_o,
  output logic    done_o,
  output logic    hold_o,
  output byte_t   snap_o
);
  rd_state_e state_q, state_d;
  byte_t     snap_q, snap_d;
  logic      snap_en;

  always_comb begin
    state_d = state_q;
    snap_d  = snap_q;
    snap_en = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      RD_IDLE: begin
        if (access_i) begin
          state_d = RD_HOLD;
          snap_d  = pack_status(irq_act_i, flags_i);
          snap_en = 1'b1;
        end
      end
      RD_HOLD: begin
        if (!access_i) begin
          state_d = RD_IDLE;
          done_o  = 1'b1;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RD_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= '0;
    else if (snap_en) snap_q <= snap_d;
  end

  assign freeze_o = access_i;
  assign hold_o   = (state_q == RD_HOLD);
  assign snap_o   = snap_q;
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ev_alarm_i,
  input  logic          ev_periodic_i,
  input  logic          ev_update_i,
  output logic          irq_no
);
  localparam logic ADDR_EN   = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  logic    srst_n;
  srcvec_t evt_v, flags, pend, en_q, en_d;
  logic    en_we, stat_access, en_read;
  logic    freeze, rd_done, hold, irq_act;
  byte_t   snap;
  logic    unused_wdata_bits;

  assign unused_wdata_bits = ^{wdata_i[DW-1:SRC_LSB+NSRC], wdata_i[SRC_LSB-1:0]};

  evt_irq_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (srst_n)
  );

  always_comb begin
    evt_v          = '0;
    evt_v[IDX_UPD] = ev_update_i;
    evt_v[IDX_ALM] = ev_alarm_i;
    evt_v[IDX_PER] = ev_periodic_i;
  end

  assign stat_access = cs_i & rd_i & (addr_i == ADDR_STAT);
  assign en_read     = cs_i & rd_i & (addr_i == ADDR_EN);

  // Enable register
  always_comb begin
    en_we = cs_i & wr_i & (addr_i == ADDR_EN);
    en_d  = wdata_i[SRC_LSB +: NSRC];
  end

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n)    en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  evt_irq_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (srst_n),
    .evt_i    (evt_v),
    .freeze_i (freeze),
    .done_i   (rd_done),
    .flags_o  (flags),
    .pend_o   (pend)
  );

  assign irq_act = |(flags & en_q);
  assign irq_no  = ~irq_act;

  evt_irq_rdport u_rd (
    .clk_i     (clk_i),
    .rst_ni    (srst_n),
    .access_i  (stat_access),
    .flags_i   (flags),
    .irq_act_i (irq_act),
    .freeze_o  (freeze),
    .done_o    (rd_done),
    .hold_o    (hold),
    .snap_o    (snap)
  );

  always_comb begin
    if (hold)         rdata_o = snap;
    else if (en_read) rdata_o = pack_enable(en_q);
    else              rdata_o = '0;
  end
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk
  import evt_irq_pkg::*;
(
  input logic          clk_i,
  input logic          srst_ni,
  input logic          cs_i,
  input logic          rd_i,
  input logic          addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_no,
  input srcvec_t       evt_v,
  input srcvec_t       flags,
  input srcvec_t       pend,
  input logic          hold
);
  logic access;
  assign access = cs_i & rd_i & addr_i;

  assert_evt_sets_flag_R2: assert property (@(posedge clk_i) disable iff (!srst_ni)
    (!access && (|evt_v)) |=> ((flags & $past(evt_v)) == $past(evt_v)));

  assert_low_nibble_zero_R3: assert property (@(posedge clk_i) disable iff (!srst_ni)
    rdata_o[SRC_LSB-1:0] == '0);

  assert_irq_has_source_R4: assert property (@(posedge clk_i) disable iff (!srst_ni)
    !irq_no |-> (|flags));

  assert_summary_at_snapshot_R5: assert property (@(posedge clk_i) disable iff (!srst_ni)
    $rose(hold) |-> (rdata_o[BIT_SUM] == !$past(irq_no)));

  assert_snapshot_stable_R6: assert property (@(posedge clk_i) disable iff (!srst_ni)
    (hold && $past(hold)) |-> $stable(rdata_o));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!srst_ni)
    $fell(hold) |-> ((flags & ~$past(pend) & ~$past(evt_v)) == '0));

  assert_no_pending_idle_R8: assert property (@(posedge clk_i) disable iff (!srst_ni)
    !hold |-> (pend == '0));
endmodule

bind evt_irq_hub evt_irq_hub_chk u_chk (
  .clk_i   (clk_i),
  .srst_ni (srst_n),
  .cs_i    (cs_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_no  (irq_no),
  .evt_v   (evt_v),
  .flags   (flags),
  .pend    (pend),
  .hold    (hold)
);

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;
  logic       clk, rst_n;
  logic       cs, rd, wr, addr;
  logic [7:0] wdata, rdata;
  logic [2:0] ev;   // [2]=periodic, [1]=alarm, [0]=update
  logic       irq_n;
  int         checks, errors;
  logic       done;

  evt_irq_hub uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ev_alarm_i(ev[1]), .ev_periodic_i(ev[2]), .ev_update_i(ev[0]),
    .irq_no(irq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] stat_val(input logic [2:0] e, input logic [2:0] f);
    return {|(e & f), f, 4'b0000};
  endfunction

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd_en(output logic [7:0] v);
    @(negedge clk); cs = 1; rd = 1; addr = 0;
    @(negedge clk); v = rdata; cs = 0; rd = 0;
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = 0;
  endtask

  // Status read held len cycles; event mask m driven at cycle ev_at (-1 = none)
  task automatic rd_stat(input int len, input int ev_at, input logic [2:0] m,
                         output logic [7:0] v);
    @(negedge clk); cs = 1; rd = 1; addr = 1;
    if (ev_at == 0) ev = m;
    @(negedge clk); ev = 0; v = rdata;
    for (int i = 1; i < len; i++) begin
      if (ev_at == i) ev = m;
      @(negedge clk); ev = 0;
      chk("R6 stable", rdata, v);
    end
    cs = 0; rd = 0; addr = 0;
    @(negedge clk);
  endtask

  initial begin
    done = 0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    checks = 0; errors = 0;
    cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0; ev = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {7'b0, irq_n}, 8'h01);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 irq after reset", {7'b0, irq_n}, 8'h01);
    rd_stat(2, -1, 3'b000, v); chk("R1 status", v, 8'h00);
    rd_en(v); chk("R1 enable", v, 8'h00);

    // Sweep all enable x flag combinations
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 8; f++) begin
        wr_reg(1'b0, {1'b0, e[2:0], 4'b0});
        pulse(f[2:0]);
        chk("R4 R2 irq level", {7'b0, irq_n}, {7'b0, ~|(e[2:0] & f[2:0])});
        rd_stat(3, -1, 3'b000, v);
        chk("R5 R9 R3 status", v, stat_val(e[2:0], f[2:0]));
        chk("R7 irq released", {7'b0, irq_n}, 8'h01);
        rd_stat(2, -1, 3'b000, v);
        chk("R7 cleared", v, 8'h00);
      end
    end

    // Enable readback
    for (int e = 0; e < 8; e++) begin
      wr_reg(1'b0, {1'b1, e[2:0], 4'b1111});
      rd_en(v); chk("R3 enable readback", v, {1'b0, e[2:0], 4'b0});
    end

    // Polling with enables off, then late enable
    wr_reg(1'b0, 8'h00);
    pulse(3'b111);
    chk("R2 polled no irq", {7'b0, irq_n}, 8'h01);
    wr_reg(1'b0, 8'h20);
    chk("R4 late enable asserts", {7'b0, irq_n}, 8'h00);
    rd_stat(2, -1, 3'b000, v); chk("R2 R5 status", v, 8'hF0);
    chk("R7 irq high", {7'b0, irq_n}, 8'h01);

    // Events arriving during a read
    wr_reg(1'b0, 8'h70);
    for (int m = 1; m < 8; m++) begin
      for (int at = 0; at < 4; at++) begin
        logic [2:0] p;
        p = m[2:0] ^ 3'b101;
        pulse(p);
        rd_stat(4, at, m[2:0], v);
        chk("R8 snapshot excludes", v, stat_val(3'b111, p));
        chk("R8 irq from parked", {7'b0, irq_n}, 8'h00);
        rd_stat(2, -1, 3'b000, v);
        chk("R8 parked applied", v, stat_val(3'b111, m[2:0]));
      end
    end

    // Write to status address ignored
    wr_reg(1'b0, 8'h00);
    pulse(3'b101);
    wr_reg(1'b1, 8'hFF);
    chk("R10 irq unchanged", {7'b0, irq_n}, 8'h01);
    rd_en(v); chk("R10 enable unchanged", v, 8'h00);
    rd_stat(2, -1, 3'b000, v); chk("R10 flags unchanged", v, 8'h50);

    // Reset mid-operation
    wr_reg(1'b0, 8'h70);
    pulse(3'b011);
    chk("R4 before reset", {7'b0, irq_n}, 8'h00);
    @(negedge clk); rst_n = 0;
    #1 chk("R1 async reset", {7'b0, irq_n}, 8'h01);
    repeat (2) @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    rd_en(v); chk("R1 enable cleared", v, 8'h00);
    rd_stat(2, -1, 3'b000, v); chk("R1 flags cleared", v, 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule